// File: doc/BRIEF.md
# Maskable Interrupt Priority and Mask Controller

This block sits beside a CPU sequencer and decides whether a maskable interrupt should be taken, and which one. It collects up to twenty request lines. Line 0 is the external request line and needs no local enable. Every other line is qualified by its own enable bit. The qualified requests go through a fixed-priority resolver, where a lower index wins. A promotion selector can lift any one source above all the others. A global mask bit blocks the resolved request from reaching the sequencer.

The global mask bit is modelled as a small sequential circuit rather than a plain flip-flop. A set command takes effect in the same cycle. This applies to the set-mask and flags-transfer instructions, to interrupt entry, and to a restore whose value is 1. A clear command, or a restore whose value is 0, lowers the bit only after one further bus cycle. A set command that arrives during that cycle cancels the pending clear.

A software interrupt bypasses the mask. The controller reports when one may begin, and it blocks all maskable service from the moment one starts until its vector fetch. At each vector-fetch strobe the controller registers the vector index, so the index stays steady through the fetch.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A source i>0 is eligible only when req_i[i] and en_i[i] are both 1; source 0 is eligible whenever req_i[0] is 1, whatever en_i[0] holds.
- R2: Among eligible sources, the lowest index wins; win_idx_o shows the winner and any_req_o is 1 whenever any source is eligible, regardless of the mask.
- R3: When promote_i holds a value below 20 and that source is eligible, it wins over all other sources.
- R4: A promote_i value of 20 or more, or naming a source that is not eligible, leaves the fixed order in force.
- R5: After reset, mask_o is 1, irq_pend_o is 0, swi_ok_o is 1 and vec_idx_o is 0.
- R6: irq_pend_o is 0 whenever mask_o is 1, and also in any cycle where mask_set_i is 1; after a set, mask_o is 1 from the next cycle.
- R7: After a single-cycle mask_clr_i pulse in cycle t, mask_o stays 1 in cycle t+1 and is 0 in cycle t+2. irq_pend_o can first be 1 in cycle t+2.
- R8: A set command in cycle t+1, following a clear in cycle t, cancels the clear, and mask_o remains 1.
- R9: entry_set_i sets mask_o in the next cycle and blocks irq_pend_o in its own cycle.
- R10: A request that arrives while masked is held by the requester. It is reported on irq_pend_o, with the correct win_idx_o, once the mask clears.
- R11: swi_ok_o is 1 only when irq_pend_o is 0 and no software interrupt is in progress; after swi_start_i, irq_pend_o stays 0 until vec_fetch_i.
- R12: On vec_fetch_i, vec_idx_o loads 20 if a software interrupt is in progress, otherwise win_idx_o; at all other times it holds its value.
- R13: restore_i with restore_val_i=1 sets the mask like a set command; with restore_val_i=0 it clears it with the same one-cycle delay as mask_clr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 20 | Request lines, bit 0 is the external line |
| en_i | input | 20 | Local enables, bit 0 unused |
| promote_i | input | 5 | Source number lifted to top priority |
| mask_set_i | input | 1 | Set-mask command (immediate) |
| mask_clr_i | input | 1 | Clear-mask command (delayed) |
| entry_set_i | input | 1 | Interrupt entry, after flags saved |
| restore_i | input | 1 | Flags restore strobe |
| restore_val_i | input | 1 | Mask value carried by the restore |
| swi_start_i | input | 1 | Software interrupt begins |
| vec_fetch_i | input | 1 | Vector fetch strobe |
| any_req_o | output | 1 | Some source eligible (ignores mask) |
| win_idx_o | output | 5 | Current winning source |
| irq_pend_o | output | 1 | Maskable interrupt to be taken |
| swi_ok_o | output | 1 | Software interrupt may start |
| mask_o | output | 1 | Global mask bit as gating |
| vec_idx_o | output | 5 | Registered vector index |

## Verification
Several results are combinational and are due in the same cycle as their stimulus: eligibility, the winner, promotion, and the immediate blocking by a set command. The bench drives these on the falling edge and samples them 1 ns later. mask_o after a set and vec_idx_o after a strobe are due one rising edge later, so the bench checks them at the following falling edge. The delayed clear is checked at two sampling points after the pulse: still masked at the first, released at the second.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC_DEF = 20;

    typedef struct packed {
        logic set_now;
        logic clr_req;
    } mask_cmd_t;

    function automatic mask_cmd_t build_cmd(input logic set_i, input logic clr_i,
                                            input logic entry_i, input logic rest_i,
                                            input logic rest_val_i);
        mask_cmd_t c;
        c.set_now = set_i | entry_i | (rest_i & rest_val_i);
        c.clr_req = clr_i | (rest_i & ~rest_val_i);
        return c;
    endfunction
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
    parameter int N_SRC = irq_pkg::NSRC_DEF
) (
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] en_i,
    output logic [N_SRC-1:0] elig_o
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_q
        if (g == 0) begin : g_ext
            assign elig_o[g] = req_i[g];
        end else begin : g_loc
            assign elig_o[g] = req_i[g] & en_i[g];
        end
    end

    always_comb begin
        assert_ext_no_enable_R1: assert (elig_o[0] == req_i[0]);
    end
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve #(
    parameter int N_SRC = irq_pkg::NSRC_DEF,
    localparam int IDX_W = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] elig_i,
    input  logic [IDX_W-1:0] promote_i,
    output logic             any_o,
    output logic [IDX_W-1:0] win_o
);
    logic [IDX_W-1:0] fixed_win;
    logic             prom_hit;

    always_comb begin
        fixed_win = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig_i[i]) fixed_win = IDX_W'(i);
        end
    end

    always_comb begin
        prom_hit = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (promote_i == IDX_W'(i) && elig_i[i]) prom_hit = 1'b1;
        end
    end

    assign any_o = |elig_i;
    assign win_o = prom_hit ? promote_i : fixed_win;

    assert_win_eligible_R2: assert property (@(posedge clk) disable iff (rst)
        any_o |-> (win_o < IDX_W'(N_SRC)) && elig_i[win_o[IDX_W-1:0] % N_SRC]);
    assert_prom_range_R4: assert property (@(posedge clk) disable iff (rst)
        (promote_i >= IDX_W'(N_SRC)) |-> (win_o == fixed_win));
endmodule

// File: rtl/irq_mask_seq.sv
module irq_mask_seq (
    input  logic              clk,
    input  logic              rst,
    input  irq_pkg::mask_cmd_t cmd_i,
    output logic              mask_q_o,
    output logic              gate_o
);
    logic mask_q;
    logic clr_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q     <= 1'b1;
            clr_pend_q <= 1'b0;
        end else if (cmd_i.set_now) begin
            mask_q     <= 1'b1;
            clr_pend_q <= 1'b0;
        end else begin
            if (clr_pend_q) mask_q <= 1'b0;
            clr_pend_q <= cmd_i.clr_req;
        end
    end

    assign mask_q_o = mask_q;
    assign gate_o   = mask_q | cmd_i.set_now;

    assert_set_next_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_i.set_now |=> mask_q);
    assert_clear_delayed_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.clr_req && !cmd_i.set_now && mask_q) |=> mask_q);
    assert_fall_needs_wait_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(mask_q) |-> $past(clr_pend_q) && !$past(cmd_i.set_now));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int N_SRC = irq_pkg::NSRC_DEF,
    localparam int IDX_W = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [IDX_W-1:0] promote_i,
    input  logic             mask_set_i,
    input  logic             mask_clr_i,
    input  logic             entry_set_i,
    input  logic             restore_i,
    input  logic             restore_val_i,
    input  logic             swi_start_i,
    input  logic             vec_fetch_i,
    output logic             any_req_o,
    output logic [IDX_W-1:0] win_idx_o,
    output logic             irq_pend_o,
    output logic             swi_ok_o,
    output logic             mask_o,
    output logic [IDX_W-1:0] vec_idx_o
);
    import irq_pkg::*;

    localparam logic [IDX_W-1:0] SWI_CODE = IDX_W'(N_SRC);

    logic [N_SRC-1:0] elig;
    logic             gate;
    logic             swi_busy_q;
    logic [IDX_W-1:0] vec_q;
    mask_cmd_t        cmd;

    assign cmd = build_cmd(mask_set_i, mask_clr_i, entry_set_i, restore_i, restore_val_i);

    irq_qualify #(.N_SRC(N_SRC)) u_qual (
        .req_i  (req_i),
        .en_i   (en_i),
        .elig_o (elig)
    );

    irq_resolve #(.N_SRC(N_SRC)) u_res (
        .clk       (clk),
        .rst       (rst),
        .elig_i    (elig),
        .promote_i (promote_i),
        .any_o     (any_req_o),
        .win_o     (win_idx_o)
    );

    irq_mask_seq u_mask (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (cmd),
        .mask_q_o (mask_o),
        .gate_o   (gate)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            swi_busy_q <= 1'b0;
            vec_q      <= '0;
        end else begin
            if (vec_fetch_i) begin
                vec_q      <= swi_busy_q ? SWI_CODE : win_idx_o;
                swi_busy_q <= 1'b0;
            end else if (swi_start_i) begin
                swi_busy_q <= 1'b1;
            end
        end
    end

    assign irq_pend_o = any_req_o & ~gate & ~swi_busy_q;
    assign swi_ok_o   = ~irq_pend_o & ~swi_busy_q;
    assign vec_idx_o  = vec_q;

    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        mask_o |-> !irq_pend_o);
    assert_swi_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        (swi_start_i && !vec_fetch_i) |=> !irq_pend_o);
    assert_vec_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !vec_fetch_i |=> $stable(vec_idx_o));
    assert_entry_sets_R9: assert property (@(posedge clk) disable iff (rst)
        entry_set_i |-> !irq_pend_o);
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
    localparam int N = 20;
    localparam int W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] req = '0, en = '0;
    logic [W-1:0] prom = 5'd31;
    logic set_c = 0, clr_c = 0, ent = 0, rest = 0, rest_v = 0, swi = 0, vf = 0;
    logic any_r, pend, swi_ok, mask;
    logic [W-1:0] win, vec;
    int errors = 0, checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst(rst), .req_i(req), .en_i(en), .promote_i(prom),
        .mask_set_i(set_c), .mask_clr_i(clr_c), .entry_set_i(ent),
        .restore_i(rest), .restore_val_i(rest_v), .swi_start_i(swi),
        .vec_fetch_i(vf), .any_req_o(any_r), .win_idx_o(win),
        .irq_pend_o(pend), .swi_ok_o(swi_ok), .mask_o(mask), .vec_idx_o(vec)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic quiet();
        @(negedge clk);
        set_c = 0; clr_c = 0; ent = 0; rest = 0; rest_v = 0; swi = 0; vf = 0;
    endtask

    task automatic do_clear();
        @(negedge clk); clr_c = 1;
        @(negedge clk); clr_c = 0;
        @(negedge clk); #1;
    endtask

    task automatic t_reset();
        step();
        chk("R5 mask", mask, 1); chk("R5 pend", pend, 0);
        chk("R5 swi_ok", swi_ok, 1); chk("R5 vec", vec, 0);
    endtask

    task automatic t_enable();
        quiet(); req = '0; en = '0; req[0] = 1; #1;
        chk("R1 ext without enable", any_r, 1); chk("R1 ext win", win, 0);
        req = '0; req[7] = 1; #1;
        chk("R1 disabled source", any_r, 0);
        en[7] = 1; #1;
        chk("R1 enabled source", any_r, 1); chk("R1 win 7", win, 7);
    endtask

    task automatic t_fixed();
        quiet(); en = '1; req = '0; req[12] = 1; req[5] = 1; req[19] = 1; #1;
        chk("R2 lowest wins", win, 5);
        req[5] = 0; #1; chk("R2 next lowest", win, 12);
        req[0] = 1; #1; chk("R2 ext highest", win, 0);
    endtask

    task automatic t_promote();
        quiet(); en = '1; req = '0; req[0] = 1; req[3] = 1; req[17] = 1;
        prom = 5'd17; #1; chk("R3 promoted wins", win, 17);
        prom = 5'd3; #1;  chk("R3 promoted over ext", win, 3);
        prom = 5'd9; #1;  chk("R4 promoted not eligible", win, 0);
        prom = 5'd20; #1; chk("R4 out of range 20", win, 0);
        prom = 5'd31; #1; chk("R4 out of range 31", win, 0);
        en[17] = 0; prom = 5'd17; #1; chk("R4 promoted disabled", win, 0);
        prom = 5'd31; en = '1;
    endtask

    task automatic t_clear_delay();
        quiet(); req = '0; req[4] = 1; en = '1; #1;
        chk("R10 masked pending held", pend, 0);
        chk("R10 winner visible while masked", win, 4);
        @(negedge clk); clr_c = 1; #1;
        chk("R7 pend in clear cycle", pend, 0);
        @(negedge clk); clr_c = 0; #1;
        chk("R7 mask held one cycle", mask, 1); chk("R7 pend held", pend, 0);
        @(negedge clk); #1;
        chk("R7 mask released", mask, 0); chk("R10 serviced after clear", pend, 1);
        chk("R10 win", win, 4);
    endtask

    task automatic t_set();
        quiet(); #1;
        chk("R6 pending before set", pend, 1);
        set_c = 1; #1; chk("R6 set blocks same cycle", pend, 0);
        @(negedge clk); set_c = 0; #1;
        chk("R6 mask after set", mask, 1); chk("R6 pend after set", pend, 0);
        do_clear(); chk("R7 reclear", pend, 1);
        @(negedge clk); ent = 1; #1; chk("R9 entry blocks", pend, 0);
        @(negedge clk); ent = 0; #1; chk("R9 entry sets mask", mask, 1);
    endtask

    task automatic t_cancel();
        quiet();
        @(negedge clk); clr_c = 1;
        @(negedge clk); clr_c = 0; set_c = 1;
        @(negedge clk); set_c = 0; #1;
        chk("R8 cancelled mask", mask, 1); chk("R8 pend", pend, 0);
        step(); chk("R8 mask stays", mask, 1);
    endtask

    task automatic t_restore();
        quiet();
        @(negedge clk); rest = 1; rest_v = 0;
        @(negedge clk); rest = 0; #1; chk("R13 restore clear delayed", mask, 1);
        step(); chk("R13 restore clear done", mask, 0);
        @(negedge clk); rest = 1; rest_v = 1; #1; chk("R13 restore set blocks", pend, 0);
        @(negedge clk); rest = 0; #1; chk("R13 restore set", mask, 1);
    endtask

    task automatic t_swi();
        quiet(); #1;
        chk("R11 swi ok while masked", swi_ok, 1);
        @(negedge clk); swi = 1;
        @(negedge clk); swi = 0; #1; chk("R11 swi busy", swi_ok, 0);
        do_clear();
        chk("R11 mask clear", mask, 0); chk("R11 pend blocked by swi", pend, 0);
        @(negedge clk); vf = 1;
        @(negedge clk); vf = 0; #1;
        chk("R12 swi code", vec, 20); chk("R11 pend after fetch", pend, 1);
        chk("R11 swi not ok while pending", swi_ok, 0);
    endtask

    task automatic t_vec();
        quiet(); req = '0; req[9] = 1; req[14] = 1; prom = 5'd14; #1;
        @(negedge clk); vf = 1;
        @(negedge clk); vf = 0; req = '0; req[2] = 1; prom = 5'd31; #1;
        chk("R12 captured winner", vec, 14);
        step(); chk("R12 holds", vec, 14);
        @(negedge clk); vf = 1;
        @(negedge clk); vf = 0; #1; chk("R12 second capture", vec, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset(); t_enable(); t_fixed(); t_promote(); t_clear_delay();
        t_set(); t_cancel(); t_restore(); t_swi(); t_vec();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule